// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small processor core and updates it after each arithmetic or logic step. Each cycle the execution stage presents an operation class together with both operands and the result it produced. The block derives carry, zero, negative, two's-complement overflow, sign and half-carry from those values alone, so it needs no access to the adder's internal carries.

Alongside the arithmetic flags it holds a user bit-copy flag and the global interrupt enable. The bit-copy flag is loaded from any chosen bit of a register value. A combinational output returns that register value with the chosen bit replaced by the stored flag. The interrupt enable is set and cleared by explicit strobes, cleared when an interrupt is taken and set again on return from one. A direct write port loads the whole word, for example when software restores a saved copy. The block never saves or restores the word by itself.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset the status word is 0x00. Bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: Operation class 1 (add, with or without carry-in) sets C to the carry out of bit 7, H to the carry out of bit 3, V when both operands have the same sign and the result's sign differs, N to result bit 7 and Z when the result is 0x00.
- R3: Operation class 2 (subtract, with or without borrow-in) sets C to the borrow out of bit 7, H to the borrow out of bit 3, V when the operands differ in sign and the result's sign differs from the first operand, N to result bit 7 and Z when the result is 0x00.
- R4: Operation class 3 (logic) clears V, sets N and Z from the result and leaves C and H unchanged.
- R5: Operation class 0 leaves H, V, N, Z and C unchanged.
- R6: S always equals N xor V, including after a direct write, whose own S bit is ignored.
- R7: A bit-store strobe copies bit `bit_sel` of `bit_src` into T at the next clock edge.
- R8: `bld_out` equals `bit_src` with bit `bit_sel` replaced by the current T, without waiting for a clock.
- R9: Taking an interrupt or the clear strobe clears I. Return-from-interrupt or the set strobe sets I. When a clearing and a setting request meet in one cycle, I is cleared.
- R10: A direct write loads I, T, H, V, N, Z and C from `wr_data` and overrides every other update in that cycle.
- R11: Taking an interrupt changes no bit other than I.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_op | input | 2 | Operation class: 0 none, 1 add, 2 subtract, 3 logic |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| alu_res | input | 8 | Result of the operation |
| ie_set | input | 1 | Set global interrupt enable |
| ie_clr | input | 1 | Clear global interrupt enable |
| irq_take | input | 1 | Interrupt being entered |
| irq_ret | input | 1 | Return from interrupt |
| bst_en | input | 1 | Copy a selected register bit into T |
| bit_sel | input | 3 | Selected bit position for bit-store and bit-load |
| bit_src | input | 8 | Register value for bit-store and bit-load |
| wr_en | input | 1 | Direct write of the status word |
| wr_data | input | 8 | Value for the direct write |
| status | output | 8 | Current status word |
| bld_out | output | 8 | `bit_src` with the selected bit replaced by T |

## Verification
On every cycle the assertions check the following:
- the sign bit stays consistent with N and V;
- a logic step clears V and keeps C and H;
- an idle step keeps all arithmetic flags;
- taking an interrupt clears I and touches nothing else;
- return-from-interrupt sets I;
- a direct write lands in full in the next cycle.

The bench's directed scenarios are what show the numeric flag values. They cover carry and borrow across bit 7 and bit 3, signed overflow on both add and subtract, the zero result, and carry-in or borrow-in changing the outcome. Those values come from the bench's own wide arithmetic. The bench scenarios also cover the combinational bit-load path and the ordering when conflicting interrupt-enable requests arrive together.

// File: rtl/psw_pkg.sv
package psw_pkg;

   typedef enum logic [1:0] {
      OPC_NONE  = 2'd0,
      OPC_ADD   = 2'd1,
      OPC_SUB   = 2'd2,
      OPC_LOGIC = 2'd3
   } opc_e;

   // field order equals the bit layout, bit 7 first
   typedef struct packed {
      logic i;
      logic t;
      logic h;
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } flags_t;

endpackage

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          HAS_HALF = 1'b1
) (
   input  opc_e              op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] r,
   input  flags_t            cur,
   output flags_t            nxt
);
   localparam int unsigned MSB  = DATA_W - 1;
   localparam int unsigned HALF = DATA_W / 2;

   // carry (or borrow) into each bit position
   logic [DATA_W-1:0] cin_vec;
   logic              carry_out;
   logic              borrow_out;
   logic              half_add;
   logic              half_sub;
   logic              res_zero;
   logic              unused_cin;

   assign cin_vec    = a ^ b ^ r;
   assign unused_cin = ^cin_vec;
   assign carry_out  = (a[MSB] & b[MSB]) | (a[MSB] & ~r[MSB]) | (b[MSB] & ~r[MSB]);
   assign borrow_out = (~a[MSB] & b[MSB]) | (b[MSB] & r[MSB]) | (r[MSB] & ~a[MSB]);
   assign res_zero   = (r == '0);

   generate
      if (HAS_HALF) begin : g_half
         assign half_add = cin_vec[HALF];
         assign half_sub = cin_vec[HALF];
      end else begin : g_no_half
         assign half_add = 1'b0;
         assign half_sub = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = cur;
      unique case (op)
         OPC_ADD: begin
            nxt.c = carry_out;
            nxt.h = half_add;
            nxt.v = cin_vec[MSB] ^ carry_out;
            nxt.n = r[MSB];
            nxt.z = res_zero;
         end
         OPC_SUB: begin
            nxt.c = borrow_out;
            nxt.h = half_sub;
            nxt.v = cin_vec[MSB] ^ borrow_out;
            nxt.n = r[MSB];
            nxt.z = res_zero;
         end
         OPC_LOGIC: begin
            nxt.v = 1'b0;
            nxt.n = r[MSB];
            nxt.z = res_zero;
         end
         default: ;
      endcase
      nxt.s = nxt.n ^ nxt.v;
   end

endmodule

// File: rtl/psw_bit_copy.sv
module psw_bit_copy #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned SEL_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] bit_src,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic              t_cur,
   output logic              t_pick,
   output logic [DATA_W-1:0] bld_out
);
   assign t_pick = bit_src[bit_sel];

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_lane
         assign bld_out[k] = (bit_sel == SEL_W'(k)) ? t_cur : bit_src[k];
      end
   endgenerate

endmodule

// File: rtl/psw_ie_ctrl.sv
module psw_ie_ctrl (
   input  logic ie_cur,
   input  logic ie_set,
   input  logic ie_clr,
   input  logic irq_take,
   input  logic irq_ret,
   output logic ie_nxt
);
   logic want_clr;
   logic want_set;

   assign want_clr = ie_clr | irq_take;
   assign want_set = ie_set | irq_ret;

   always_comb begin
      if (want_clr)      ie_nxt = 1'b0;
      else if (want_set) ie_nxt = 1'b1;
      else               ie_nxt = ie_cur;
   end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          HAS_HALF = 1'b1,
   localparam int unsigned SEL_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        alu_op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              ie_set,
   input  logic              ie_clr,
   input  logic              irq_take,
   input  logic              irq_ret,
   input  logic              bst_en,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic [DATA_W-1:0] bit_src,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        status,
   output logic [DATA_W-1:0] bld_out
);

   initial begin : elab_checks
      assert (DATA_W >= 4 && DATA_W % 2 == 0)
         else $error("psw_flag_unit: DATA_W must be even and at least 4");
      assert (DATA_W == (1 << SEL_W))
         else $error("psw_flag_unit: DATA_W must be a power of two");
   end

   flags_t st_q;
   flags_t st_d;
   flags_t alu_nxt;
   logic   t_pick;
   logic   ie_nxt;
   opc_e   op;

   assign op = opc_e'(alu_op);

   psw_arith_flags #(
      .DATA_W   (DATA_W),
      .HAS_HALF (HAS_HALF)
   ) u_arith (
      .op  (op),
      .a   (opnd_a),
      .b   (opnd_b),
      .r   (alu_res),
      .cur (st_q),
      .nxt (alu_nxt)
   );

   psw_bit_copy #(
      .DATA_W (DATA_W)
   ) u_bitcp (
      .bit_src (bit_src),
      .bit_sel (bit_sel),
      .t_cur   (st_q.t),
      .t_pick  (t_pick),
      .bld_out (bld_out)
   );

   psw_ie_ctrl u_ie (
      .ie_cur   (st_q.i),
      .ie_set   (ie_set),
      .ie_clr   (ie_clr),
      .irq_take (irq_take),
      .irq_ret  (irq_ret),
      .ie_nxt   (ie_nxt)
   );

   always_comb begin
      st_d   = alu_nxt;
      st_d.i = ie_nxt;
      st_d.t = bst_en ? t_pick : st_q.t;
      if (wr_en) st_d = flags_t'(wr_data);
      st_d.s = st_d.n ^ st_d.v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign status = st_q;

   // R6: sign consistency of the stored word
   a_r6_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] == (status[2] ^ status[3]));

   // R4: logic step clears V and keeps C and H
   a_r4_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 2'd3 && !wr_en) |=>
         (!status[3] && status[0] == $past(status[0]) && status[5] == $past(status[5])));

   // R5: idle step keeps arithmetic flags
   a_r5_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 2'd0 && !wr_en) |=>
         (status[5] == $past(status[5]) && status[3:0] == $past(status[3:0])));

   // R9: interrupt entry clears I
   a_r9_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && !wr_en) |=> !status[7]);

   // R9: return sets I when nothing clears it
   a_r9_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_take && !ie_clr && !wr_en) |=> status[7]);

   // R11: interrupt entry touches only I
   a_r11_no_autosave: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && !wr_en && !bst_en && alu_op == 2'd0) |=> $stable(status[6:0]));

   // R10: direct write wins
   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (status[7:5] == $past(wr_data[7:5]) && status[3:0] == $past(wr_data[3:0])));

endmodule

// File: tb/sim_psw_flag_unit.sv
module sim_psw_flag_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] alu_op;
   logic [7:0] opnd_a, opnd_b, alu_res;
   logic       ie_set, ie_clr, irq_take, irq_ret, bst_en, wr_en;
   logic [2:0] bit_sel;
   logic [7:0] bit_src, wr_data;
   logic [7:0] status, bld_out;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_st;

   always #(CLK_PERIOD/2) clk = ~clk;

   psw_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .alu_res(alu_res), .ie_set(ie_set), .ie_clr(ie_clr), .irq_take(irq_take),
      .irq_ret(irq_ret), .bst_en(bst_en), .bit_sel(bit_sel), .bit_src(bit_src),
      .wr_en(wr_en), .wr_data(wr_data), .status(status), .bld_out(bld_out)
   );

   function automatic logic [7:0] pack(input logic i, t, h, v, n, z, c);
      return {i, t, h, n ^ v, v, n, z, c};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle_inputs;
      alu_op = 2'd0; opnd_a = '0; opnd_b = '0; alu_res = '0;
      ie_set = 0; ie_clr = 0; irq_take = 0; irq_ret = 0; bst_en = 0;
      bit_sel = '0; bit_src = '0; wr_en = 0; wr_data = '0;
   endtask

   // inputs are set just after a falling edge; one rising edge passes
   task automatic step;
      @(negedge clk);
   endtask

   task automatic arith(input logic sub, input logic [7:0] a, input logic [7:0] b,
                        input logic cin, input string req);
      logic [8:0] full;
      logic [7:0] r;
      logic c, h, v;
      if (!sub) begin
         full = {1'b0, a} + {1'b0, b} + 9'(cin);
         c = full[8];
         h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin)) > 5'd15;
      end else begin
         full = {1'b0, a} - {1'b0, b} - 9'(cin);
         c = {1'b0, a} < ({1'b0, b} + 9'(cin));
         h = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + 5'(cin));
      end
      r = full[7:0];
      v = sub ? ((a[7] != b[7]) && (r[7] != a[7])) : ((a[7] == b[7]) && (r[7] != a[7]));
      alu_op = sub ? 2'd2 : 2'd1;
      opnd_a = a; opnd_b = b; alu_res = r;
      step();
      exp_st = pack(exp_st[7], exp_st[6], h, v, r[7], r == 8'h00, c);
      check(req, status, exp_st);
      idle_inputs();
   endtask

   task automatic t_reset;
      check("R1 reset value", status, 8'h00);
      exp_st = 8'h00;
   endtask

   task automatic t_add;
      arith(1'b0, 8'h0F, 8'h01, 1'b0, "R2 half carry");
      arith(1'b0, 8'h80, 8'h80, 1'b0, "R2 carry overflow zero");
      arith(1'b0, 8'h7F, 8'h01, 1'b0, "R2 positive overflow");
      arith(1'b0, 8'hFF, 8'h00, 1'b1, "R2 carry-in wraps");
      arith(1'b0, 8'h12, 8'h34, 1'b0, "R2 plain add");
   endtask

   task automatic t_sub;
      arith(1'b1, 8'h00, 8'h01, 1'b0, "R3 borrow negative");
      arith(1'b1, 8'h80, 8'h01, 1'b0, "R3 signed overflow");
      arith(1'b1, 8'h05, 8'h05, 1'b0, "R3 zero result");
      arith(1'b1, 8'h05, 8'h04, 1'b1, "R3 borrow-in gives zero");
   endtask

   task automatic t_logic;
      arith(1'b1, 8'h00, 8'h01, 1'b0, "R3 preset C and H");
      alu_op = 2'd3; opnd_a = 8'hF0; opnd_b = 8'h0F; alu_res = 8'h00;
      step();
      exp_st = pack(exp_st[7], exp_st[6], exp_st[5], 1'b0, 1'b0, 1'b1, exp_st[0]);
      check("R4 logic zero keeps C H", status, exp_st);
      idle_inputs();
      arith(1'b0, 8'h7F, 8'h01, 1'b0, "R2 preset V");
      alu_op = 2'd3; opnd_a = 8'hC3; opnd_b = 8'hFF; alu_res = 8'hC3;
      step();
      exp_st = pack(exp_st[7], exp_st[6], exp_st[5], 1'b0, 1'b1, 1'b0, exp_st[0]);
      check("R4 logic clears V", status, exp_st);
      idle_inputs();
   endtask

   task automatic t_none;
      opnd_a = 8'hAA; opnd_b = 8'h55; alu_res = 8'h00;
      step();
      check("R5 idle class keeps flags", status, exp_st);
      idle_inputs();
   endtask

   task automatic t_bitcopy;
      bst_en = 1; bit_src = 8'h20; bit_sel = 3'd5;
      step();
      exp_st[6] = 1'b1;
      check("R7 bit-store sets T", status, exp_st);
      idle_inputs();
      bit_src = 8'h00; bit_sel = 3'd3;
      #1;
      check("R8 bit-load inserts T", bld_out, 8'h08);
      bst_en = 1; bit_src = 8'hFE; bit_sel = 3'd0;
      step();
      exp_st[6] = 1'b0;
      check("R7 bit-store clears T", status, exp_st);
      idle_inputs();
      bit_src = 8'hFF; bit_sel = 3'd7;
      #1;
      check("R8 bit-load clears bit 7", bld_out, 8'h7F);
      idle_inputs();
   endtask

   task automatic t_irq;
      bst_en = 1; bit_src = 8'h01; bit_sel = 3'd0;
      step();
      exp_st[6] = 1'b1;
      idle_inputs();
      ie_set = 1;
      step();
      exp_st[7] = 1'b1;
      check("R9 set strobe", status, exp_st);
      idle_inputs();
      irq_take = 1;
      step();
      exp_st[7] = 1'b0;
      check("R11 entry changes only I", status, exp_st);
      idle_inputs();
      irq_ret = 1;
      step();
      exp_st[7] = 1'b1;
      check("R9 return sets I", status, exp_st);
      idle_inputs();
      ie_set = 1; ie_clr = 1;
      step();
      exp_st[7] = 1'b0;
      check("R9 clear wins over set", status, exp_st);
      idle_inputs();
      irq_ret = 1; irq_take = 1;
      step();
      check("R9 entry wins over return", status, exp_st);
      idle_inputs();
   endtask

   task automatic t_write;
      wr_en = 1; wr_data = 8'hFF;
      alu_op = 2'd1; opnd_a = 8'h00; opnd_b = 8'h00; alu_res = 8'h00;
      ie_clr = 1; bst_en = 1; bit_src = 8'h00;
      step();
      exp_st = 8'hEF;
      check("R10 write overrides updates", status, exp_st);
      idle_inputs();
      wr_en = 1; wr_data = 8'h10;
      step();
      exp_st = 8'h00;
      check("R6 written S ignored", status, exp_st);
      idle_inputs();
      wr_en = 1; wr_data = 8'h08;
      step();
      exp_st = 8'h18;
      check("R6 S recomputed from V", status, exp_st);
      idle_inputs();
      wr_en = 1; wr_data = 8'h0C;
      step();
      exp_st = 8'h0C;
      check("R6 N and V cancel", status, exp_st);
      idle_inputs();
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_none();
      t_bitcopy();
      t_irq();
      t_write();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule